// File: doc/BRIEF.md
# SPI Register-Access Bridge

This block is an SPI target that gives an external host read and write access to the 32-bit registers of a chip. The host drives a mode 0 link (clock idle low, data sampled on the rising edge and launched on the falling edge) and frames each transaction with an active-low select. Every frame carries a 24-bit header, most significant bit first. The header holds a write flag and a word address. One 32-bit word follows, either written by the host or returned by the block. On the chip side the block masters a level request/acknowledge register bus. That bus may take a variable number of cycles to answer.

Because internal reads may be slow, the host can ask for a number of idle padding bytes between the header and the read data. If a bus answer is still missing when the first data bit must leave, the block sends zeros and raises a sticky flag. The host can pick one of four byte and bit orders for the payload, while the header always stays most significant bit first. Two small local registers hold these settings and are never forwarded to the bus: a control word at word address 0 and a configuration/status word at word address 1. The SPI pins are oversampled by the system clock through synchronizers, so the system clock must run several times faster than the SPI clock.

Top module: `spi_reg_bridge`

## Requirements
- R1: A frame begins with a 24-bit header sent most significant bit first. Header bit 23 (the first bit) is the write flag, with 1 for a write and 0 for a read. Bits 22:0 are the word address. Each frame makes at most one register access.
- R2: In a write frame, the 32 data bits follow the header directly. Once the last data bit is sampled, the block issues exactly one bus write carrying the reassembled word. A bus request stays high until it is acknowledged.
- R3: In a read frame, the bus read is requested as soon as the header completes. The block then ignores 8*N padding bits on MOSI. The 32 data bits then appear on MISO, each launched on an SCK falling edge so the host can sample it on the next rising edge.
- R4: Payload format, where wire bit k (k = 0 is sent first) has byte slot j = k/8 and in-byte position b = k%8. Control bit 0 selects the byte order: 0 means slot j carries word byte j, and 1 means slot j carries word byte 3-j. Control bit 1 selects the bit order: 0 sends bit 7-b, and 1 sends bit b. The header is never reordered.
- R5: A write to word address 0 sets the format from bits 1:0 of the word as reassembled under the format in force. A read of word address 0 returns the format in bits 1:0 and zeros elsewhere. Accesses to word addresses 0 and 1 never reach the bus.
- R6: Word address 1 holds the padding count N in bits 3:0, which is read/write. Bits 31:24 are read-only and read 2, the code for this access path. Every other bit reads 0 except bit 16.
- R7: Bit 16 of word address 1 is a sticky error. It is set when read data is not available at the falling edge that launches the first data bit. In that case MISO carries all zeros for the whole word.
- R8: Reading the status word leaves bit 16 unchanged. Writing 1 to bit 16 clears it. Writing 0 to bit 16 leaves it set.
- R9: If select rises before the last bit of a write frame, no register changes: there is no bus write and no local register update.
- R10: The MISO output enable equals the inverse of the select input at all times, so MISO is released whenever select is high.
- R11: After reset the format is 0, N is 0, the sticky flag is clear and no bus request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| spi_miso_oe | output | 1 | Output enable for MISO (1 = drive) |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 23 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Single-cycle acknowledge of the pending request |

## Verification
The assertions assume a well-behaved bus and host. The bus raises its acknowledge only while a request is pending. Each SCK level lasts several system clocks. Select never reopens before the previous frame's bus access has been acknowledged. The bench keeps within these limits in three ways. It holds each SCK level for eight clocks. Its bus responder only answers a pending request. It leaves an idle gap of dozens of clocks after every frame, which is longer than the largest bus latency it programs. The slow-response case uses a latency that lands inside the frame but after the first data bit is due.

// File: rtl/spib_pkg.sv
// Package: shared constants and the payload bit-placement function.
// Assumes a 32-bit payload word; the wire/word mapping depends on that.
package spib_pkg;

    localparam int WORD_BITS = 32;
    localparam logic [7:0] PATH_ID = 8'd2;   // access-path code of this interface

    // Map wire bit k (0 = first on the wire) to the word bit it carries.
    // fmt[0]: 1 = big-endian byte order; fmt[1]: 1 = LSB of each byte first.
    function automatic logic [4:0] wire_pos(input logic [1:0] fmt, input logic [4:0] k);
        logic [1:0] slot;
        logic [2:0] b;
        logic [1:0] byte_sel;
        logic [2:0] bit_sel;
        slot     = k[4:3];
        b        = k[2:0];
        byte_sel = fmt[0] ? (2'd3 - slot) : slot;
        bit_sel  = fmt[1] ? b : (3'd7 - b);
        return {byte_sel, bit_sel};
    endfunction

endpackage

// File: rtl/spib_sync.sv
// Module: spib_sync
// Brings a group of asynchronous pins into the clk domain through a chain
// of STAGES flops each. Assumes the pins change far slower than clk.
module spib_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop of the chain: capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= d;
            end
        end else begin : g_next
            // Later flops: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= RST_VAL;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spib_frame.sv
// Module: spib_frame
// Serial frame engine. It counts SCK edges within a select window, collects
// the header and write payload, starts one access per frame, and launches
// read data on falling edges after the padding. Assumes synchronised inputs
// and each SCK level lasting several clk cycles.
module spib_frame
    import spib_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int PAD_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_s,
    input  logic                 csn_s,
    input  logic                 mosi_s,
    input  logic [1:0]           fmt,
    input  logic [PAD_W-1:0]     pad_n,
    input  logic                 rd_valid,
    input  logic [WORD_BITS-1:0] rd_data,
    output logic                 acc_start,
    output logic                 acc_we,
    output logic [ADDR_W-1:0]    acc_addr,
    output logic [WORD_BITS-1:0] acc_wdata,
    output logic                 frame_start,
    output logic                 miss_pulse,
    output logic                 miso_d
);
    localparam int HDR_BITS = ADDR_W + 1;
    localparam int MAX_BITS = HDR_BITS + 8 * ((1 << PAD_W) - 1) + WORD_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam logic [CNT_W-1:0] HDR_C  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] WEND_C = CNT_W'(HDR_BITS + WORD_BITS);
    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_BITS);

    logic                 sck_q, csn_q;
    logic [CNT_W-1:0]     cnt;
    logic [HDR_BITS-2:0]  hdr;
    logic                 we_r, miss_r;
    logic [ADDR_W-1:0]    addr_r;
    logic [WORD_BITS-1:0] wdat;
    logic                 acc_done;

    logic                 rise, fall;
    logic [CNT_W-1:0]     rd_first, k_full, wk_full;
    logic                 in_data, in_wdata;
    logic [4:0]           rpos, wpos;

    // Edge detection and data-phase window decode.
    always_comb begin
        rise        = sck_s & ~sck_q & ~csn_s;
        fall        = ~sck_s & sck_q & ~csn_s;
        frame_start = csn_q & ~csn_s;
        rd_first    = HDR_C + CNT_W'({pad_n, 3'b000});
        k_full      = cnt - rd_first;
        wk_full     = cnt - HDR_C;
        in_data     = ~we_r & (cnt >= rd_first) & (k_full < CNT_W'(WORD_BITS));
        in_wdata    = we_r & (cnt >= HDR_C) & (cnt < WEND_C);
        rpos        = wire_pos(fmt, k_full[4:0]);
        wpos        = wire_pos(fmt, wk_full[4:0]);
    end

    // Frame sequencer: header shift, payload capture, access start, MISO launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            csn_q      <= 1'b1;
            cnt        <= '0;
            hdr        <= '0;
            we_r       <= 1'b0;
            miss_r     <= 1'b0;
            addr_r     <= '0;
            wdat       <= '0;
            acc_start  <= 1'b0;
            miss_pulse <= 1'b0;
            miso_d     <= 1'b0;
        end else begin
            sck_q      <= sck_s;
            csn_q      <= csn_s;
            acc_start  <= 1'b0;
            miss_pulse <= 1'b0;
            if (csn_s) begin
                cnt    <= '0;
                we_r   <= 1'b0;
                miss_r <= 1'b0;
                miso_d <= 1'b0;
            end else begin
                if (rise) begin
                    if (cnt < HDR_C - 1'b1) begin
                        hdr <= {hdr[HDR_BITS-3:0], mosi_s};
                    end
                    if (cnt == HDR_C - 1'b1) begin
                        we_r   <= hdr[HDR_BITS-2];
                        addr_r <= {hdr[ADDR_W-2:0], mosi_s};
                        if (!hdr[HDR_BITS-2]) acc_start <= 1'b1;
                    end
                    if (in_wdata) begin
                        wdat[wpos] <= mosi_s;
                        if (cnt == WEND_C - 1'b1) acc_start <= 1'b1;
                    end
                    if (cnt != MAX_C) cnt <= cnt + 1'b1;
                end
                if (fall) begin
                    if (in_data) begin
                        if (k_full == '0) begin
                            if (rd_valid) begin
                                miso_d <= rd_data[rpos];
                            end else begin
                                miso_d     <= 1'b0;
                                miss_r     <= 1'b1;
                                miss_pulse <= 1'b1;
                            end
                        end else begin
                            miso_d <= miss_r ? 1'b0 : rd_data[rpos];
                        end
                    end else begin
                        miso_d <= 1'b0;
                    end
                end
            end
        end
    end

    // Tracks whether this frame already started its access (checked below).
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_done <= 1'b0;
        else if (csn_s)     acc_done <= 1'b0;
        else if (acc_start) acc_done <= 1'b1;
    end

    assign acc_we    = we_r;
    assign acc_addr  = addr_r;
    assign acc_wdata = wdat;

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |-> !acc_done) else $error("second access in one frame"); // R1
    AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && acc_we) |-> !csn_s) else $error("write after select rose"); // R9
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && miss_r) |=> (miso_d == 1'b0)) else $error("data after miss"); // R7
endmodule

// File: rtl/spib_regs.sv
// Module: spib_regs
// Local control/status registers and the register-bus master. Word
// addresses 0 and 1 are served here; any other address becomes a bus
// request held until acknowledged. Assumes the bus acks only a pending
// request and that the host does not open a frame while one is pending.
module spib_regs
    import spib_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int PAD_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_start,
    input  logic                 acc_we,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [WORD_BITS-1:0] acc_wdata,
    input  logic                 frame_start,
    input  logic                 miss_pulse,
    output logic [1:0]           fmt,
    output logic [PAD_W-1:0]     pad_n,
    output logic                 rd_valid,
    output logic [WORD_BITS-1:0] rd_data,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [WORD_BITS-1:0] bus_wdata,
    input  logic [WORD_BITS-1:0] bus_rdata,
    input  logic                 bus_ack
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(1);
    localparam int ERR_BIT = 16;

    logic                 err;
    logic                 want;
    logic                 is_ctrl, is_stat;
    logic                 clr_err;
    logic [WORD_BITS-1:0] ctrl_word, stat_word;

    // Local address decode and readback words.
    always_comb begin
        is_ctrl   = (acc_addr == CTRL_A);
        is_stat   = (acc_addr == STAT_A);
        clr_err   = acc_start & acc_we & is_stat & acc_wdata[ERR_BIT];
        ctrl_word = '0;
        ctrl_word[1:0] = fmt;
        stat_word = '0;
        stat_word[WORD_BITS-1:WORD_BITS-8] = PATH_ID;
        stat_word[ERR_BIT]     = err;
        stat_word[PAD_W-1:0]   = pad_n;
    end

    // Register updates, read-response capture and bus request handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt       <= 2'b00;
            pad_n     <= '0;
            err       <= 1'b0;
            want      <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            if (frame_start) begin
                rd_valid <= 1'b0;
                want     <= 1'b0;
            end
            if (acc_start) begin
                if (is_ctrl || is_stat) begin
                    if (acc_we) begin
                        if (is_ctrl) fmt <= acc_wdata[1:0];
                        else         pad_n <= acc_wdata[PAD_W-1:0];
                        if (clr_err) err <= 1'b0;
                    end else begin
                        rd_data  <= is_ctrl ? ctrl_word : stat_word;
                        rd_valid <= 1'b1;
                    end
                end else begin
                    bus_req   <= 1'b1;
                    bus_we    <= acc_we;
                    bus_addr  <= acc_addr;
                    bus_wdata <= acc_wdata;
                    want      <= ~acc_we;
                end
            end
            if (bus_req && bus_ack) begin
                bus_req <= 1'b0;
                if (want) begin
                    rd_data  <= bus_rdata;
                    rd_valid <= 1'b1;
                    want     <= 1'b0;
                end
            end
            if (miss_pulse) begin
                want <= 1'b0;
                err  <= 1'b1;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req) else $error("request dropped"); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err) |=> err) else $error("sticky flag lost"); // R8
    AST_FRESH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !acc_start && !(bus_req && bus_ack)) |=> !rd_valid)
        else $error("stale read data"); // R3
endmodule

// File: rtl/spi_reg_bridge.sv
// Module: spi_reg_bridge (top)
// SPI mode 0 target bridging host frames to a request/acknowledge register
// bus. Assumes clk runs several times faster than SCK.
module spi_reg_bridge
    import spib_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int PAD_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    logic [2:0]           pins_s;
    logic                 acc_start, acc_we, frame_start, miss_pulse, rd_valid;
    logic [ADDR_W-1:0]    acc_addr;
    logic [WORD_BITS-1:0] acc_wdata, rd_data;
    logic [1:0]           fmt;
    logic [PAD_W-1:0]     pad_n;

    spib_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s)
    );

    spib_frame #(.ADDR_W(ADDR_W), .PAD_W(PAD_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[1]), .csn_s(pins_s[2]), .mosi_s(pins_s[0]),
        .fmt(fmt), .pad_n(pad_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .frame_start(frame_start),
        .miss_pulse(miss_pulse), .miso_d(spi_miso)
    );

    spib_regs #(.ADDR_W(ADDR_W), .PAD_W(PAD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .frame_start(frame_start),
        .miss_pulse(miss_pulse), .fmt(fmt), .pad_n(pad_n),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // Output enable follows the select pin directly.
    assign spi_miso_oe = ~spi_cs_n;

    AST_OE_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_miso_oe) else $error("MISO driven while idle"); // R10
endmodule

// File: tb/sim_spi_reg_bridge.sv
`timescale 1ns/1ps
module sim_spi_reg_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, bus_req, bus_we, bus_ack = 1'b0;
    logic [22:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;

    int checks = 0, errors = 0, bus_lat = 4, exp_rd = 0;
    bit finished = 0;
    logic [1:0] fmt_m = 2'b00;
    int pad_m = 0;
    logic err_m = 1'b0;
    logic [31:0] mem [int];
    logic [54:0] exp_wr_q [$];

    always #10 clk = ~clk;

    spi_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_val(input int a);
        return mem.exists(a) ? mem[a] : (32'hDEAD0000 ^ 32'(a));
    endfunction

    // Reference encoding: word -> wire order (first bit at index 31).
    function automatic logic [31:0] to_wire(input logic [1:0] f, input logic [31:0] v);
        logic [31:0] w; logic [7:0] by; int k = 0;
        for (int j = 0; j < 4; j++) begin
            by = f[0] ? v[8*(3-j) +: 8] : v[8*j +: 8];
            for (int b = 0; b < 8; b++) begin
                w[31-k] = f[1] ? by[b] : by[7-b];
                k++;
            end
        end
        return w;
    endfunction

    function automatic logic [31:0] from_wire(input logic [1:0] f, input logic [31:0] w);
        logic [31:0] v; int k = 0;
        for (int j = 0; j < 4; j++) begin
            for (int b = 0; b < 8; b++) begin
                v[8*(f[0] ? 3-j : j) + (f[1] ? b : 7-b)] = w[31-k];
                k++;
            end
        end
        return v;
    endfunction

    // Behavioural bus responder; also checks every handshake.
    int lat_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; lat_cnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0; lat_cnt = 0;
        end else if (bus_req) begin
            lat_cnt++;
            if (lat_cnt >= bus_lat) begin
                bus_ack = 1'b1;
                if (bus_we) begin
                    if (exp_wr_q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R9/R5: actual=unexpected write %h:%h expected=none", bus_addr, bus_wdata);
                    end else begin
                        check("R2 write addr+data", {9'd0, bus_addr} ^ bus_wdata,
                              {9'd0, exp_wr_q[0][54:32]} ^ exp_wr_q[0][31:0]);
                        check("R2 write data", bus_wdata, exp_wr_q[0][31:0]);
                        void'(exp_wr_q.pop_front());
                    end
                    mem[int'(bus_addr)] = bus_wdata;
                end else begin
                    if (exp_rd == 0) begin
                        checks++; errors++;
                        $display("FAIL R5: actual=unexpected read %h expected=none", bus_addr);
                    end else exp_rd--;
                    bus_rdata = mem_val(int'(bus_addr));
                end
            end
        end
    end

    // Per-clock comparison of the output enable against select (R10).
    always @(negedge clk) begin
        if (rst_n && !finished) check("R10 miso_oe", {31'd0, miso_oe}, {31'd0, ~cs_n});
    end

    // One SPI frame; stop_at > 0 cuts the frame after that many bits.
    task automatic frame(input bit we, input int addr, input logic [31:0] wval,
                         input int stop_at, output logic [31:0] rval);
        logic tx[$]; logic rx[$]; logic [31:0] w; int total;
        logic [23:0] hdr;
        hdr = {we, 23'(addr)};
        for (int i = 23; i >= 0; i--) tx.push_back(hdr[i]);
        if (we) begin
            w = to_wire(fmt_m, wval);
            for (int i = 31; i >= 0; i--) tx.push_back(w[i]);
        end else begin
            for (int i = 0; i < 8*pad_m; i++) tx.push_back(1'b1);
            for (int i = 0; i < 32; i++) tx.push_back(1'b0);
        end
        total = (stop_at > 0) ? stop_at : tx.size();
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            mosi = tx[i];
            repeat (8) @(negedge clk);
            rx.push_back(miso);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (60) @(negedge clk);
        w = '0;
        if (!we && stop_at == 0)
            for (int i = 0; i < 32; i++) w[31-i] = rx[24 + 8*pad_m + i];
        rval = from_wire(fmt_m, w);
    endtask

    task automatic wr(input int addr, input logic [31:0] v);
        logic [31:0] d;
        if (addr >= 2) exp_wr_q.push_back({23'(addr), v});
        frame(1'b1, addr, v, 0, d);
        if (addr == 0) fmt_m = v[1:0];
        if (addr == 1) begin
            pad_m = int'(v[3:0]);
            if (v[16]) err_m = 1'b0;
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] v);
        if (addr >= 2) exp_rd++;
        frame(1'b0, addr, '0, 0, v);
    endtask

    function automatic logic [31:0] stat_exp();
        return {8'd2, 7'd0, err_m, 12'd0, 4'(pad_m)};
    endfunction

    initial begin
        repeat (4000 * 40) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 no request after reset", {31'd0, bus_req}, 32'd0);
        rd(1, v); check("R11/R6 status after reset", v, 32'h0200_0000);
        rd(0, v); check("R11/R5 control after reset", v, 32'd0);

        // R5: format change, replicated value
        wr(0, 32'h0101_0101);
        rd(0, v); check("R5/R4 control readback fmt01", v, 32'd1);

        // R2 write, R6 padding programming, R3 padded read
        wr(32'h123, 32'hA5C3_1E77);
        wr(1, 32'h0000_0002);
        rd(1, v); check("R6 status with N=2", v, stat_exp());
        rd(32'h123, v); check("R3 padded read", v, 32'hA5C3_1E77);

        // R7 miss with N=0 and slow bus
        wr(1, 32'h0000_0000);
        bus_lat = 20;
        rd(32'h123, v); check("R7 zeros on miss", v, 32'd0);
        err_m = 1'b1;
        rd(1, v); check("R7 sticky set", v, stat_exp());
        rd(1, v); check("R8 read keeps sticky", v, stat_exp());
        wr(1, 32'h0000_0003);
        rd(1, v); check("R8 write 0 keeps sticky", v, stat_exp());
        wr(1, 32'h0001_0003);
        rd(1, v); check("R8 write 1 clears", v, 32'h0200_0003);
        rd(32'h123, v); check("R7 no miss with N=3", v, 32'hA5C3_1E77);
        rd(1, v); check("R7 flag stays clear", v, 32'h0200_0003);
        bus_lat = 4;

        // R4 every format, R1 high address bits
        for (int f = 0; f < 4; f++) begin
            wr(0, {4{6'd0, 2'(f)}});
            rd(0, v); check("R4 fmt readback", v, 32'(f));
            wr(32'h40_0000 | f, 32'h1234_5678 ^ (32'h1111_0000 * f));
            rd(32'h40_0000 | f, v);
            check("R4/R1 roundtrip", v, 32'h1234_5678 ^ (32'h1111_0000 * f));
        end

        // R9 aborted write frames
        frame(1'b1, 32'h77, 32'hCAFE_F00D, 40, v);
        exp_rd++;
        frame(1'b0, 32'h77, '0, 0, v); check("R9 aborted bus write", v, mem_val(32'h77));
        frame(1'b1, 0, 32'h0, 50, v);
        rd(0, v); check("R9 aborted control write", v, 32'd3);

        // R11 reset returns defaults mid-run
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fmt_m = 2'b00; pad_m = 0; err_m = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, v); check("R11 status after reset", v, 32'h0200_0000);
        rd(0, v); check("R11 control after reset", v, 32'd0);

        check("R2 all writes seen", 32'(exp_wr_q.size()), 32'd0);
        check("R3 all reads seen", 32'(exp_rd), 32'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule